// File: doc/BRIEF.md
# SMBus host register and status unit

This block is the software-facing register front end of an SMBus master. A byte-wide register port lets a processor set up a transaction (slave address with direction flag, command code, up to two data bytes, a block byte, a checksum byte and two auxiliary mode bits), choose a protocol in the control register and launch it with a start bit. The block hands a one-cycle start request and the set-up fields to a separate protocol engine, then keeps a status register that the engine's completion, error and per-byte reports update.

Status flags are cleared by writing ones to them. One level-held interrupt line covers completion, every error flag and the per-byte handshake, gated by an enable bit in the control register. A kill bit written during a transaction aborts it at once: busy drops, the failed flag is set and the engine receives a one-cycle kill request. Read data follow the address combinationally. A read strobe marks a consuming read, which matters only for the in-use semaphore flag.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0x00, busy is clear, `irq` is low and neither `eng_start` nor `eng_kill` is asserted.
- R2: The register offsets are: status 0, control 2, command 3, slave address 4, data0 5, data1 6, block data 7, checksum byte 8, auxiliary status 12 and auxiliary control 13. Auxiliary control keeps only bits 1:0. Unmapped offsets read 0x00 and writes to them change nothing. The slave address register (7-bit address in bits 7:1, read flag in bit 0) drives `eng_addr` unchanged, and the other set-up registers drive their own engine outputs.
- R3: Control bits are: 0 interrupt enable, 1 kill, 4:2 protocol code, 5 last byte, 6 start, 7 checksum enable. Writing start=1 and kill=0 while idle sets busy (status bit 0), pulses `eng_start` for one cycle and drives `eng_proto` with bits 4:2. Start always reads back as 0.
- R4: A start written while busy is set is ignored: no `eng_start` pulse, busy stays set and `eng_proto` keeps the running protocol.
- R5: `eng_done` while busy clears busy. With no error input it sets status bit 1 (completion). With `eng_dev_err` it sets bit 2 instead. With `eng_bus_err` it sets bit 3 instead.
- R6: Writing kill=1 while busy clears busy, sets status bit 4 (failed) and pulses `eng_kill`. An `eng_done` that arrives after the abort sets no flag. Kill written while idle does nothing.
- R7: A write to status clears every flag whose data bit is 1 and leaves the flags under a 0 unchanged. Busy cannot be written.
- R8: `irq` is high while interrupt enable is set and any of status bits 7, 4, 3, 2 or 1 is set. It stays high until those flags are cleared or the enable is cleared.
- R9: `eng_byte_done` during a transaction sets status bit 7 (byte done) and leaves busy set.
- R10: A high `smb_alert` sets status bit 5. This flag does not drive `irq`.
- R11: A status read with `reg_rd` high returns the in-use flag (bit 6) as it was, then sets it. Writing 1 to bit 6 clears it.
- R12: `eng_rx_we` writes `eng_rx_data` into data0 when `eng_rx_sel` is 0, into data1 when it is 1 and into block data when it is 2. For a word result, data0 holds the low byte and data1 the high byte.
- R13: `eng_done` with `eng_crc_err` sets auxiliary status bit 0, and writing 1 to that bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Consuming-read strobe (in-use flag) |
| reg_rdata | output | 8 | Read data for reg_addr |
| eng_start | output | 1 | One-cycle transaction request |
| eng_kill | output | 1 | One-cycle abort request |
| eng_proto | output | 3 | Protocol code latched at start |
| eng_pec_en | output | 1 | Checksum enable from control |
| eng_last | output | 1 | Last-byte flag from control |
| eng_addr | output | 8 | Slave address and read flag |
| eng_cmd | output | 8 | Command code |
| eng_data0 | output | 8 | Data0 register |
| eng_data1 | output | 8 | Data1 register |
| eng_blk | output | 8 | Block data register |
| eng_pec | output | 8 | Checksum byte register |
| eng_aux | output | 2 | Auxiliary mode bits |
| eng_done | input | 1 | Engine reports end of transaction |
| eng_dev_err | input | 1 | Device error qualifier for eng_done |
| eng_bus_err | input | 1 | Bus error qualifier for eng_done |
| eng_crc_err | input | 1 | Checksum error qualifier for eng_done |
| eng_byte_done | input | 1 | Engine reports one byte handled |
| eng_rx_we | input | 1 | Engine writes received data |
| eng_rx_sel | input | 2 | Received-data target: 0 data0, 1 data1, 2 block |
| eng_rx_data | input | 8 | Received byte |
| smb_alert | input | 1 | Alert input from the bus |
| irq | output | 1 | Level interrupt |

## Verification
Every set-up register is written with a distinct byte and read back, along with unmapped and partly-writable offsets, which shows whether offsets alias. Transactions are ended four ways: clean completion, device error, bus error and kill. Each must leave exactly one distinct status flag and the right interrupt level, so a swapped or merged flag is caught. Starts written while busy, kills written while idle, late completions after an abort and alerts with interrupts enabled show that the gating is right. The last two cases would otherwise set a flag or raise the interrupt by mistake.

// File: rtl/smb_host_pkg.sv
// Shared constants for the SMBus host register unit: register offsets,
// status and control bit positions, protocol codes and received-data slots.
// Assumes an 8-bit register port.
package smb_host_pkg;
    localparam int DW = 8;

    localparam int OFS_STAT  = 0;
    localparam int OFS_CTRL  = 2;
    localparam int OFS_CMD   = 3;
    localparam int OFS_SADDR = 4;
    localparam int OFS_D0    = 5;
    localparam int OFS_D1    = 6;
    localparam int OFS_BLK   = 7;
    localparam int OFS_PEC   = 8;
    localparam int OFS_AUXS  = 12;
    localparam int OFS_AUXC  = 13;

    localparam int ST_BUSY  = 0;
    localparam int ST_INTR  = 1;
    localparam int ST_DEV   = 2;
    localparam int ST_BUS   = 3;
    localparam int ST_FAIL  = 4;
    localparam int ST_ALERT = 5;
    localparam int ST_INUSE = 6;
    localparam int ST_BYTE  = 7;

    localparam int CT_IEN   = 0;
    localparam int CT_KILL  = 1;
    localparam int CT_PLO   = 2;
    localparam int CT_PHI   = 4;
    localparam int CT_LAST  = 5;
    localparam int CT_START = 6;
    localparam int CT_PEC   = 7;

    localparam int PW = CT_PHI - CT_PLO + 1;
    localparam int AUXW = 2;

    localparam logic [DW-1:0] IRQ_MASK = 8'h9E;

    typedef enum logic [PW-1:0] {
        PR_QUICK = 3'd0,
        PR_BYTE  = 3'd1,
        PR_BDATA = 3'd2,
        PR_WDATA = 3'd3,
        PR_PCALL = 3'd4,
        PR_BLOCK = 3'd5,
        PR_I2CRD = 3'd6
    } proto_e;

    // Plain byte registers, indexed as slots of the register file.
    localparam int NPLAIN = 6;
    localparam int PLAIN_OFS [NPLAIN] = '{OFS_CMD, OFS_SADDR, OFS_D0, OFS_D1, OFS_BLK, OFS_PEC};
    localparam int SLOT_CMD = 0;
    localparam int SLOT_SADDR = 1;
    localparam int SLOT_D0 = 2;
    localparam int SLOT_D1 = 3;
    localparam int SLOT_BLK = 4;
    localparam int SLOT_PEC = 5;

    // Map of the engine's received-data select onto a register slot.
    function automatic int rx_slot(input logic [1:0] sel);
        case (sel)
            2'd0:    return SLOT_D0;
            2'd1:    return SLOT_D1;
            2'd2:    return SLOT_BLK;
            default: return -1;
        endcase
    endfunction
endpackage

// File: rtl/smb_reg_file.sv
// Set-up registers of the SMBus host: command, slave address, two data bytes,
// block byte, checksum byte (one generated slot each) and the auxiliary mode bits.
// Software writes win over engine receive writes in the same cycle.
module smb_reg_file
    import smb_host_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rx_we,
    input  logic [1:0]    rx_sel,
    input  logic [DW-1:0] rx_data,
    output logic [DW-1:0] slot_q [NPLAIN],
    output logic [AUXW-1:0] auxc_q
);
    for (genvar g = 0; g < NPLAIN; g++) begin : g_slot
        logic sw_hit;
        logic rx_hit;
        assign sw_hit = wr_en && (wr_addr == AW'(PLAIN_OFS[g]));
        assign rx_hit = rx_we && (rx_slot(rx_sel) == g);

        // Holds one set-up byte, loaded by software or by the engine.
        always_ff @(posedge clk) begin
            if (!rst_n)      slot_q[g] <= '0;
            else if (sw_hit) slot_q[g] <= wr_data;
            else if (rx_hit) slot_q[g] <= rx_data;
        end
    end

    // Holds the auxiliary mode bits; upper bits of the write are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) auxc_q <= '0;
        else if (wr_en && wr_addr == AW'(OFS_AUXC)) auxc_q <= wr_data[AUXW-1:0];
    end
endmodule

// File: rtl/smb_ctrl_seq.sv
// Control register and transaction sequencing: decodes start and kill,
// keeps busy, latches the protocol at start and qualifies engine completion.
// Assumes eng_done is a one-cycle pulse from the protocol engine.
module smb_ctrl_seq
    import smb_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wr_data,
    input  logic          eng_done,
    output logic [DW-1:0] ctrl_q,
    output logic          busy,
    output logic          start_p,
    output logic          kill_p,
    output logic [PW-1:0] proto_q,
    output logic          kill_fire,
    output logic          done_acc
);
    logic start_fire;

    // Decodes the start and kill requests of this cycle.
    always_comb begin
        kill_fire  = ctl_wr && wr_data[CT_KILL] && busy;
        start_fire = ctl_wr && wr_data[CT_START] && !wr_data[CT_KILL] && !busy;
        done_acc   = busy && eng_done && !kill_fire;
    end

    // Stores the control byte; start is self-clearing and never kept.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (ctl_wr) begin
            ctrl_q <= wr_data;
            ctrl_q[CT_START] <= 1'b0;
        end
    end

    // Tracks busy from start until completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                       busy <= 1'b0;
        else if (kill_fire || done_acc)   busy <= 1'b0;
        else if (start_fire)              busy <= 1'b1;
    end

    // Issues one-cycle requests to the engine and latches the protocol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_p <= 1'b0;
            kill_p  <= 1'b0;
            proto_q <= PR_QUICK;
        end else begin
            start_p <= start_fire;
            kill_p  <= kill_fire;
            if (start_fire) proto_q <= wr_data[CT_PHI:CT_PLO];
        end
    end
endmodule

// File: rtl/smb_status.sv
// Status flags with write-one-to-clear, auxiliary checksum flag and the
// interrupt gate. A set and a clear of one flag in the same cycle leave it set.
module smb_status
    import smb_host_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_wr,
    input  logic          stat_rd,
    input  logic [DW-1:1] clr_bits,
    input  logic          auxs_clr,
    input  logic          busy,
    input  logic          done_acc,
    input  logic          kill_fire,
    input  logic          dev_err,
    input  logic          bus_err,
    input  logic          crc_err,
    input  logic          byte_done,
    input  logic          alert,
    input  logic          ien,
    output logic [DW-1:0] stat_val,
    output logic          auxs_q,
    output logic          irq
);
    logic [DW-1:1] flg_q;
    logic [DW-1:1] flg_set;
    logic [DW-1:1] flg_clr;

    // Collects the flag set requests of this cycle.
    always_comb begin
        flg_set = '0;
        flg_set[ST_INTR]  = done_acc && !dev_err && !bus_err;
        flg_set[ST_DEV]   = done_acc && dev_err;
        flg_set[ST_BUS]   = done_acc && bus_err;
        flg_set[ST_FAIL]  = kill_fire;
        flg_set[ST_ALERT] = alert;
        flg_set[ST_INUSE] = stat_rd;
        flg_set[ST_BYTE]  = byte_done && busy;
        flg_clr = stat_wr ? clr_bits : '0;
    end

    // Updates the status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= (flg_q & ~flg_clr) | flg_set;
    end

    // Updates the auxiliary checksum error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                 auxs_q <= 1'b0;
        else if (done_acc && crc_err) auxs_q <= 1'b1;
        else if (auxs_clr)          auxs_q <= 1'b0;
    end

    // Forms the visible status byte and the gated interrupt level.
    always_comb begin
        stat_val = {flg_q, busy};
        irq = ien && (|(stat_val & IRQ_MASK));
    end
endmodule

// File: rtl/smb_host_regs.sv
// Top of the SMBus host register unit: byte register port, read mux and the
// wiring of register file, control sequencer and status block to the engine.
// Read data follow reg_addr combinationally; reg_rd only marks a consuming read.
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            reg_wr,
    input  logic            reg_rd,
    output logic [DW-1:0]   reg_rdata,
    output logic            eng_start,
    output logic            eng_kill,
    output logic [PW-1:0]   eng_proto,
    output logic            eng_pec_en,
    output logic            eng_last,
    output logic [DW-1:0]   eng_addr,
    output logic [DW-1:0]   eng_cmd,
    output logic [DW-1:0]   eng_data0,
    output logic [DW-1:0]   eng_data1,
    output logic [DW-1:0]   eng_blk,
    output logic [DW-1:0]   eng_pec,
    output logic [AUXW-1:0] eng_aux,
    input  logic            eng_done,
    input  logic            eng_dev_err,
    input  logic            eng_bus_err,
    input  logic            eng_crc_err,
    input  logic            eng_byte_done,
    input  logic            eng_rx_we,
    input  logic [1:0]      eng_rx_sel,
    input  logic [DW-1:0]   eng_rx_data,
    input  logic            smb_alert,
    output logic            irq
);
    logic [DW-1:0]   slot_q [NPLAIN];
    logic [AUXW-1:0] auxc_q;
    logic [DW-1:0]   ctrl_q;
    logic [DW-1:0]   stat_val;
    logic            busy, kill_fire, done_acc, auxs_q, ien;
    logic            ctl_wr, stat_wr, auxs_wr, stat_rd;

    // Decodes the register strobes per offset.
    always_comb begin
        ctl_wr  = reg_wr && reg_addr == AW'(OFS_CTRL);
        stat_wr = reg_wr && reg_addr == AW'(OFS_STAT);
        auxs_wr = reg_wr && reg_addr == AW'(OFS_AUXS);
        stat_rd = reg_rd && reg_addr == AW'(OFS_STAT);
        ien     = ctrl_q[CT_IEN];
    end

    smb_reg_file #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .rx_we(eng_rx_we), .rx_sel(eng_rx_sel),
        .rx_data(eng_rx_data), .slot_q(slot_q), .auxc_q(auxc_q)
    );

    smb_ctrl_seq u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_data(reg_wdata),
        .eng_done(eng_done), .ctrl_q(ctrl_q), .busy(busy), .start_p(eng_start),
        .kill_p(eng_kill), .proto_q(eng_proto), .kill_fire(kill_fire),
        .done_acc(done_acc)
    );

    smb_status u_stat (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_rd(stat_rd),
        .clr_bits(reg_wdata[DW-1:1]), .auxs_clr(auxs_wr && reg_wdata[0]),
        .busy(busy), .done_acc(done_acc), .kill_fire(kill_fire),
        .dev_err(eng_dev_err), .bus_err(eng_bus_err), .crc_err(eng_crc_err),
        .byte_done(eng_byte_done), .alert(smb_alert), .ien(ien),
        .stat_val(stat_val), .auxs_q(auxs_q), .irq(irq)
    );

    // Drives the set-up fields to the engine.
    always_comb begin
        eng_pec_en = ctrl_q[CT_PEC];
        eng_last   = ctrl_q[CT_LAST];
        eng_cmd    = slot_q[SLOT_CMD];
        eng_addr   = slot_q[SLOT_SADDR];
        eng_data0  = slot_q[SLOT_D0];
        eng_data1  = slot_q[SLOT_D1];
        eng_blk    = slot_q[SLOT_BLK];
        eng_pec    = slot_q[SLOT_PEC];
        eng_aux    = auxc_q;
    end

    // Selects the read data for the addressed register.
    always_comb begin
        case (reg_addr)
            AW'(OFS_STAT):  reg_rdata = stat_val;
            AW'(OFS_CTRL):  reg_rdata = ctrl_q;
            AW'(OFS_CMD):   reg_rdata = slot_q[SLOT_CMD];
            AW'(OFS_SADDR): reg_rdata = slot_q[SLOT_SADDR];
            AW'(OFS_D0):    reg_rdata = slot_q[SLOT_D0];
            AW'(OFS_D1):    reg_rdata = slot_q[SLOT_D1];
            AW'(OFS_BLK):   reg_rdata = slot_q[SLOT_BLK];
            AW'(OFS_PEC):   reg_rdata = slot_q[SLOT_PEC];
            AW'(OFS_AUXS):  reg_rdata = {{(DW-1){1'b0}}, auxs_q};
            AW'(OFS_AUXC):  reg_rdata = {{(DW-AUXW){1'b0}}, auxc_q};
            default:        reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/smb_host_regs_chk.sv
// Checker for the SMBus host register unit, bound to the top module.
module smb_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [7:0] stat,
    input logic       eng_start,
    input logic       eng_kill,
    input logic       eng_done,
    input logic       eng_byte_done,
    input logic       irq,
    input logic       ien
);
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !$past(busy));

    a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> !busy);

    a_r6_kill_fails: assert property (@(posedge clk) disable iff (!rst_n)
        eng_kill |-> (!busy && stat[4]));

    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

    a_r8_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(stat & 8'h9E)));

    a_r9_byte_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat[7]) && $past(busy) && !$past(eng_done) && !eng_kill) |-> busy);

    a_r9_byte_needs_report: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[7]) |-> $past(eng_byte_done));
endmodule

bind smb_host_regs smb_host_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .stat(stat_val),
    .eng_start(eng_start), .eng_kill(eng_kill), .eng_done(eng_done),
    .eng_byte_done(eng_byte_done), .irq(irq), .ien(ien)
);

// File: tb/smb_host_regs_tb.sv
`timescale 1ns/1ps
module smb_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       eng_start, eng_kill, eng_pec_en, eng_last;
    logic [2:0] eng_proto;
    logic [7:0] eng_addr, eng_cmd, eng_data0, eng_data1, eng_blk, eng_pec;
    logic [1:0] eng_aux;
    logic       eng_done = 0, eng_dev_err = 0, eng_bus_err = 0, eng_crc_err = 0;
    logic       eng_byte_done = 0, eng_rx_we = 0, smb_alert = 0;
    logic [1:0] eng_rx_sel = '0;
    logic [7:0] eng_rx_data = '0;
    logic       irq;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    smb_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_kill(eng_kill), .eng_proto(eng_proto),
        .eng_pec_en(eng_pec_en), .eng_last(eng_last), .eng_addr(eng_addr),
        .eng_cmd(eng_cmd), .eng_data0(eng_data0), .eng_data1(eng_data1),
        .eng_blk(eng_blk), .eng_pec(eng_pec), .eng_aux(eng_aux),
        .eng_done(eng_done), .eng_dev_err(eng_dev_err), .eng_bus_err(eng_bus_err),
        .eng_crc_err(eng_crc_err), .eng_byte_done(eng_byte_done),
        .eng_rx_we(eng_rx_we), .eng_rx_sel(eng_rx_sel), .eng_rx_data(eng_rx_data),
        .smb_alert(smb_alert), .irq(irq)
    );

    // Vectors: {offset, write byte, expected read-back}.
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {4'd3,  8'hA5, 8'hA5}, {4'd4,  8'h91, 8'h91}, {4'd5,  8'h3C, 8'h3C},
        {4'd6,  8'hC3, 8'hC3}, {4'd7,  8'h7E, 8'h7E}, {4'd8,  8'h5A, 8'h5A},
        {4'd13, 8'hFF, 8'h03}, {4'd9,  8'hFF, 8'h00}, {4'd15, 8'hFF, 8'h00},
        {4'd1,  8'hFF, 8'h00}, {4'd2,  8'hA1, 8'hA1}, {4'd0,  8'hFF, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input bit strobe, output logic [7:0] d);
        reg_addr = a; reg_rd = strobe;
        #0.5 d = reg_rdata;
        if (strobe) begin
            @(negedge clk);
            reg_rd = 1'b0;
        end
    endtask

    task automatic finish_xact(input bit dev, input bit bus, input bit crc);
        @(negedge clk);
        eng_done = 1; eng_dev_err = dev; eng_bus_err = bus; eng_crc_err = crc;
        @(negedge clk);
        eng_done = 0; eng_dev_err = 0; eng_bus_err = 0; eng_crc_err = 0;
    endtask

    task automatic rx(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        eng_rx_we = 1; eng_rx_sel = sel; eng_rx_data = d;
        @(negedge clk);
        eng_rx_we = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, 0, v); check("R1 status", v, 8'h00);
        rd(4'd2, 0, v); check("R1 control", v, 8'h00);
        rd(4'd3, 0, v); check("R1 command", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 eng_start", {7'd0, eng_start}, 8'h00);

        // R2 register map walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], 0, v);
            check($sformatf("R2 offset %0d", VEC[i][19:16]), v, VEC[i][7:0]);
        end
        check("R2 eng_addr", eng_addr, 8'h91);
        check("R2 eng_cmd", eng_cmd, 8'hA5);
        check("R2 eng_pec", eng_pec, 8'h5A);
        check("R2 eng_aux", {6'd0, eng_aux}, 8'h03);
        check("R3 eng_last/pec_en", {6'd0, eng_pec_en, eng_last}, 8'h03);

        // R3 start: byte-data, interrupt enable
        wr(4'd2, 8'h49);
        check("R3 eng_start pulse", {7'd0, eng_start}, 8'h01);
        check("R3 eng_proto", {5'd0, eng_proto}, 8'h02);
        rd(4'd2, 0, v); check("R3 start reads 0", v, 8'h09);
        rd(4'd0, 0, v); check("R3 busy", v, 8'h01);
        @(negedge clk);
        check("R3 pulse one cycle", {7'd0, eng_start}, 8'h00);

        // R4 start while busy
        wr(4'd2, 8'h55);
        check("R4 no pulse", {7'd0, eng_start}, 8'h00);
        check("R4 proto kept", {5'd0, eng_proto}, 8'h02);
        rd(4'd0, 0, v); check("R4 still busy", v, 8'h01);

        // R5 clean completion, R8 irq
        finish_xact(0, 0, 0);
        rd(4'd0, 0, v); check("R5 completion", v, 8'h02);
        check("R8 irq on completion", {7'd0, irq}, 8'h01);

        // R7 write one to clear
        wr(4'd0, 8'h01);
        rd(4'd0, 0, v); check("R7 zero bits kept, busy not writable", v, 8'h02);
        wr(4'd0, 8'h02);
        rd(4'd0, 0, v); check("R7 cleared", v, 8'h00);
        check("R8 irq drops", {7'd0, irq}, 8'h00);

        // R5 device error, R13 checksum error, R8 masked
        wr(4'd2, 8'h4C);
        check("R3 word proto", {5'd0, eng_proto}, 8'h03);
        finish_xact(1, 0, 1);
        rd(4'd0, 0, v); check("R5 device error", v, 8'h04);
        check("R8 irq masked", {7'd0, irq}, 8'h00);
        rd(4'd12, 0, v); check("R13 aux set", v, 8'h01);
        wr(4'd12, 8'h01);
        rd(4'd12, 0, v); check("R13 aux cleared", v, 8'h00);
        wr(4'd2, 8'h01);
        check("R8 irq on enable", {7'd0, irq}, 8'h01);
        wr(4'd0, 8'h04);
        check("R8 irq cleared", {7'd0, irq}, 8'h00);

        // R5 bus error
        wr(4'd2, 8'h41);
        finish_xact(0, 1, 0);
        rd(4'd0, 0, v); check("R5 bus error", v, 8'h08);
        check("R8 irq bus error", {7'd0, irq}, 8'h01);
        wr(4'd0, 8'h08);

        // R6 kill while busy
        wr(4'd2, 8'h41);
        wr(4'd2, 8'h03);
        check("R6 eng_kill", {7'd0, eng_kill}, 8'h01);
        rd(4'd0, 0, v); check("R6 failed, idle", v, 8'h10);
        check("R8 irq on failed", {7'd0, irq}, 8'h01);
        finish_xact(0, 0, 0);
        rd(4'd0, 0, v); check("R6 late done ignored", v, 8'h10);
        wr(4'd0, 8'h10);
        wr(4'd2, 8'h03);
        check("R6 idle kill no pulse", {7'd0, eng_kill}, 8'h00);
        rd(4'd0, 0, v); check("R6 idle kill no flag", v, 8'h00);

        // R9 byte done, R12 receive into block
        wr(4'd2, 8'h55);
        check("R3 block proto", {5'd0, eng_proto}, 8'h05);
        @(negedge clk); eng_byte_done = 1;
        @(negedge clk); eng_byte_done = 0;
        rd(4'd0, 0, v); check("R9 byte done, busy", v, 8'h81);
        check("R9 irq", {7'd0, irq}, 8'h01);
        wr(4'd0, 8'h80);
        rd(4'd0, 0, v); check("R9 byte cleared", v, 8'h01);
        rx(2'd2, 8'h33);
        rd(4'd7, 0, v); check("R12 block byte", v, 8'h33);
        finish_xact(0, 0, 0);
        wr(4'd0, 8'h02);

        // R12 word result
        rx(2'd0, 8'h34);
        rx(2'd1, 8'h12);
        rd(4'd5, 0, v); check("R12 data0 low", v, 8'h34);
        rd(4'd6, 0, v); check("R12 data1 high", v, 8'h12);
        check("R12 eng_data0", eng_data0, 8'h34);
        check("R12 eng_data1", eng_data1, 8'h12);

        // R10 alert
        @(negedge clk); smb_alert = 1;
        @(negedge clk); smb_alert = 0;
        rd(4'd0, 0, v); check("R10 alert flag", v, 8'h20);
        check("R10 alert no irq", {7'd0, irq}, 8'h00);
        wr(4'd0, 8'h20);

        // R11 in-use semaphore
        @(negedge clk);
        rd(4'd0, 1, v); check("R11 first read", v, 8'h00);
        rd(4'd0, 0, v); check("R11 now set", v, 8'h40);
        wr(4'd0, 8'h40);
        rd(4'd0, 0, v); check("R11 cleared", v, 8'h00);

        summary();
    end
endmodule